// File: doc/BRIEF.md
# MSI Vector Interrupt Aggregator

This block gathers message-signalled interrupts into a single level interrupt line for a host processor. Each vector owns one 32-bit word in a vector window. An interrupt message for vector n is a write to that word, and its data must equal n. Reading the same word acknowledges the vector and clears its pending bit. A separate control bank holds three words: the pending-status word, a sticky error word and an interrupt-enable word. The number of vectors is a parameter of at most 32.

Each of the three bus channels accepts a request on every cycle, so its ready output is held high. The message-write channel carries only writes and the acknowledge channel carries only reads. Because they are separate channels, a new message and an acknowledge can reach the same vector in the same cycle. Read data from the acknowledge channel and from the control bank returns one cycle after the request, flagged by a response-valid output. Software reads the status word once, then acknowledges the set bits from the lowest index up before it reads status again.

Top module: `msi_vec_aggr`

## Requirements
- R1: After reset the status, error and enable words read as zero and `irq` is low.
- R2: Control-bank word offsets are 0x0 for status, 0x4 for error and 0x8 for enable. Offset 0xC and any access with address bits [1:0] not zero read as zero and have no effect. Enable, status and error bits at or above NUM_VEC read as zero.
- R3: A message write to byte offset 4·n with data n, with n below NUM_VEC and enable bit n set, makes status bit n read 1. If enable bit n is 0, the message is discarded and bit n stays 0.
- R4: A read of the slot at byte offset 4·n returns bit 0 = 1 if vector n was pending and 0 otherwise, with all other bits zero, and clears pending bit n. A read of a slot at or above NUM_VEC, or at an address with bits [1:0] not zero, returns 0 and changes nothing. Every slot read yields a response one cycle later.
- R5: Writing the status word has no effect on any pending bit.
- R6: `irq` is high exactly when any status bit is set. It falls in the cycle after the last pending bit is cleared.
- R7: If a valid message and a slot read for the same enabled vector are accepted in the same cycle, the vector stays pending. That read returns the state the vector had before the new message.
- R8: Error bit 0 is set by a message whose data differs from its slot index. Error bit 1 is set by a message to a slot at or above NUM_VEC or to an address with bits [1:0] not zero. Neither kind of message sets a pending bit. Error bits stay set until 1 is written to them at offset 0x4. A new error in the same cycle as that write leaves the bit set.
- R9: Clearing an enable bit drops that vector's pending bit. Writing 0 to the enable word clears all pending bits and drives `irq` low.
- R10: Pending bits are independent: reading one slot clears only that vector and leaves every other pending bit as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message write request |
| msg_ready | output | 1 | Always high |
| msg_addr | input | VW_AW | Byte address within the vector window |
| msg_data | input | 32 | Message data |
| ack_valid | input | 1 | Slot read (acknowledge) request |
| ack_ready | output | 1 | Always high |
| ack_addr | input | VW_AW | Byte address of the slot to read |
| ack_rvalid | output | 1 | Slot read response valid |
| ack_rdata | output | 32 | Slot read data, bit 0 = was pending |
| reg_valid | input | 1 | Control-bank request |
| reg_ready | output | 1 | Always high |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Control-bank byte offset |
| reg_wdata | input | 32 | Control-bank write data |
| reg_rvalid | output | 1 | Control-bank read response valid |
| reg_rdata | output | 32 | Control-bank read data |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench steps through every enable pattern of a five-vector build. For each pattern it sends a message to every vector and then acknowledges them from the lowest index up. This catches a design that latches disabled vectors, because status would not equal the enable pattern. It also catches an acknowledge that clears neighbouring bits or lowers `irq` too early. The bench drives a message and an acknowledge to one vector in the same cycle, because a design that let the clear win would lose an interrupt. It also drives an error-clear write and a new error in the same cycle, because a design that let the clear win would hide the new fault. It sends messages with a wrong data value, to an unimplemented slot and to a misaligned address. A design that latched any of these would raise a spurious interrupt instead of setting an error bit.

// File: rtl/msi_vec_aggr.sv
module msi_vec_aggr #(
  parameter int NUM_VEC = 32,
  parameter int VW_AW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [VW_AW-1:0] msg_addr,
  input  logic [31:0]      msg_data,
  input  logic             ack_valid,
  output logic             ack_ready,
  input  logic [VW_AW-1:0] ack_addr,
  output logic             ack_rvalid,
  output logic [31:0]      ack_rdata,
  input  logic             reg_valid,
  output logic             reg_ready,
  input  logic             reg_write,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic             reg_rvalid,
  output logic [31:0]      reg_rdata,
  output logic             irq
);
  localparam int SLOT_W = VW_AW - 2;
  localparam logic [NUM_VEC-1:0] ONE = NUM_VEC'(1);

  logic [NUM_VEC-1:0] pend_q, mask_q, mask_nx, msg_hot, ack_hot, set_vec, clr_vec;
  logic [1:0]         err_q, err_set, err_clr;
  logic [SLOT_W-1:0]  msg_slot, ack_slot;
  logic               msg_in, ack_in, data_ok, reg_ok, wr_mask, wr_err;
  logic [31:0]        rd_mux;

  assign msg_ready = 1'b1;
  assign ack_ready = 1'b1;
  assign reg_ready = 1'b1;

  assign msg_slot = msg_addr[VW_AW-1:2];
  assign ack_slot = ack_addr[VW_AW-1:2];
  assign msg_in   = (msg_addr[1:0] == 2'b00) && (32'(msg_slot) < 32'(NUM_VEC));
  assign ack_in   = (ack_addr[1:0] == 2'b00) && (32'(ack_slot) < 32'(NUM_VEC));
  assign data_ok  = msg_data == 32'(msg_slot);
  assign msg_hot  = msg_in ? (ONE << msg_slot) : '0;
  assign ack_hot  = ack_in ? (ONE << ack_slot) : '0;

  assign set_vec  = (msg_valid && data_ok) ? (msg_hot & mask_q) : '0;
  assign clr_vec  = ack_valid ? ack_hot : '0;

  assign reg_ok   = reg_valid && (reg_addr[1:0] == 2'b00);
  assign wr_mask  = reg_ok && reg_write && (reg_addr[3:2] == 2'd2);
  assign wr_err   = reg_ok && reg_write && (reg_addr[3:2] == 2'd1);
  assign mask_nx  = wr_mask ? reg_wdata[NUM_VEC-1:0] : mask_q;

  assign err_set  = msg_valid ? {!msg_in, msg_in && !data_ok} : 2'b00;
  assign err_clr  = wr_err ? reg_wdata[1:0] : 2'b00;

  always_comb begin
    rd_mux = '0;
    if (reg_ok) begin
      case (reg_addr[3:2])
        2'd0:    rd_mux = 32'(pend_q);
        2'd1:    rd_mux = 32'(err_q);
        2'd2:    rd_mux = 32'(mask_q);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      mask_q     <= '0;
      err_q      <= '0;
      ack_rvalid <= 1'b0;
      ack_rdata  <= '0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      pend_q     <= ((pend_q & ~clr_vec) | set_vec) & mask_nx;
      mask_q     <= mask_nx;
      err_q      <= (err_q & ~err_clr) | err_set;
      ack_rvalid <= ack_valid;
      ack_rdata  <= {31'b0, ack_valid && |(pend_q & ack_hot)};
      reg_rvalid <= reg_valid && !reg_write;
      reg_rdata  <= (reg_valid && !reg_write) ? rd_mux : '0;
    end
  end

  assign irq = |pend_q;
endmodule

// File: rtl/msi_vec_aggr_chk.sv
module msi_vec_aggr_chk #(
  parameter int NUM_VEC = 32,
  parameter int VW_AW   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_valid,
  input logic [VW_AW-1:0]   msg_addr,
  input logic [31:0]        msg_data,
  input logic               ack_valid,
  input logic [VW_AW-1:0]   ack_addr,
  input logic               ack_rvalid,
  input logic               reg_valid,
  input logic               reg_write,
  input logic [3:0]         reg_addr,
  input logic [31:0]        reg_wdata,
  input logic               irq,
  input logic [NUM_VEC-1:0] pend_q,
  input logic [NUM_VEC-1:0] mask_q,
  input logic [1:0]         err_q
);
  logic [NUM_VEC-1:0] m_hot, a_hot;
  logic m_good, mask_wr, err_wr, stat_wr;

  assign m_hot   = (msg_valid && msg_addr[1:0] == 2'b00) ? (NUM_VEC'(1) << msg_addr[VW_AW-1:2]) : '0;
  assign a_hot   = (ack_valid && ack_addr[1:0] == 2'b00) ? (NUM_VEC'(1) << ack_addr[VW_AW-1:2]) : '0;
  assign m_good  = msg_data == 32'(msg_addr[VW_AW-1:2]);
  assign mask_wr = reg_valid && reg_write && reg_addr == 4'h8;
  assign err_wr  = reg_valid && reg_write && reg_addr == 4'h4;
  assign stat_wr = reg_valid && reg_write && reg_addr == 4'h0;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hot != '0 && (m_hot & a_hot) == '0) |=> (pend_q & $past(a_hot)) == '0); // R4
  AST_ACK_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> ack_rvalid); // R4
  AST_SAME_CYCLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_hot & a_hot & mask_q) != '0 && m_good && !mask_wr) |=> (pend_q & $past(a_hot)) != '0); // R7
  AST_DISABLED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_hot != '0 && (m_hot & mask_q) == '0 && (m_hot & pend_q) == '0) |=> (pend_q & $past(m_hot)) == '0); // R3
  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !msg_valid && !ack_valid) |=> $stable(pend_q)); // R5
  AST_IRQ_FALL_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ack_valid || mask_wr)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q[0]) |-> $past(err_wr && reg_wdata[0])); // R8
  AST_MASK_ZERO_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && reg_wdata == 32'h0) |=> (pend_q == '0 && !irq)); // R9
endmodule

bind msi_vec_aggr msi_vec_aggr_chk #(.NUM_VEC(NUM_VEC), .VW_AW(VW_AW)) u_chk (.*);

// File: tb/test_msi_vec_aggr.sv
`timescale 1ns/1ps
module test_msi_vec_aggr;
  localparam int NV = 5;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_valid = 1'b0, ack_valid = 1'b0, reg_valid = 1'b0, reg_write = 1'b0;
  logic [AW-1:0] msg_addr = '0, ack_addr = '0;
  logic [31:0] msg_data = '0, reg_wdata = '0;
  logic [3:0] reg_addr = '0;
  logic msg_ready, ack_ready, ack_rvalid, reg_ready, reg_rvalid, irq;
  logic [31:0] ack_rdata, reg_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  msi_vec_aggr #(.NUM_VEC(NV), .VW_AW(AW)) i_msi_vec_aggr (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic msg(input int slot, input int data);
    msg_valid = 1; msg_addr = AW'(slot * 4); msg_data = 32'(data);
    @(negedge clk); msg_valid = 0;
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_valid = 0; reg_write = 0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    @(negedge clk); reg_valid = 0; d = reg_rvalid ? reg_rdata : 32'hDEAD;
  endtask

  task automatic ack_rd(input int slot, output logic [31:0] d);
    ack_valid = 1; ack_addr = AW'(slot * 4);
    @(negedge clk); ack_valid = 0; d = ack_rvalid ? ack_rdata : 32'hDEAD;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] rest;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    reg_rd(4'h0, d); chk("R1 status", d, 0);
    reg_rd(4'h4, d); chk("R1 error", d, 0);
    reg_rd(4'h8, d); chk("R1 enable", d, 0);
    chk("R1 irq", 32'(irq), 0);

    msg(0, 0);
    reg_rd(4'h0, d); chk("R3 disabled dropped", d, 0);

    for (int m = 0; m < 32; m++) begin
      reg_wr(4'h8, 32'(m) | 32'hFFFF_FFE0);
      reg_rd(4'h8, d); chk("R2 enable readback", d, 32'(m));
      for (int n = 0; n < NV; n++) msg(n, n);
      reg_rd(4'h0, d); chk("R3 status equals enables", d, 32'(m));
      chk("R6 irq with pending", 32'(irq), 32'(m != 0));
      rest = 32'(m);
      for (int n = 0; n < NV; n++) begin
        ack_rd(n, d); chk("R4 slot read value", d, (32'(m) >> n) & 1);
        rest = rest & ~(32'd1 << n);
        reg_rd(4'h0, d); chk("R10 remaining pending", d, rest);
        chk("R6 irq follows status", 32'(irq), 32'(rest != 0));
      end
    end

    reg_wr(4'h8, 32'h1F);
    msg(0, 0); msg(2, 2);
    reg_wr(4'h0, 32'h0);
    reg_rd(4'h0, d); chk("R5 status write ignored", d, 32'h5);
    reg_wr(4'h0, 32'hFFFF_FFFF);
    reg_rd(4'h0, d); chk("R5 status write ones ignored", d, 32'h5);
    reg_rd(4'hC, d); chk("R2 unused offset", d, 0);
    reg_rd(4'h1, d); chk("R2 misaligned read", d, 0);
    ack_rd(7, d); chk("R4 out-of-range read", d, 0);
    reg_rd(4'h0, d); chk("R4 out-of-range no clear", d, 32'h5);

    reg_wr(4'h8, 32'h1B);
    reg_rd(4'h0, d); chk("R9 disable drops pending", d, 32'h1);
    reg_wr(4'h8, 32'h0);
    reg_rd(4'h0, d); chk("R9 zero enables", d, 0);
    chk("R9 irq low", 32'(irq), 0);

    reg_wr(4'h8, 32'h1F);
    msg(3, 3);
    msg_valid = 1; msg_addr = AW'(12); msg_data = 3;
    ack_valid = 1; ack_addr = AW'(12);
    @(negedge clk); msg_valid = 0; ack_valid = 0;
    chk("R7 read sees prior state", ack_rdata, 1);
    reg_rd(4'h0, d); chk("R7 stays pending", d, 32'h8);
    ack_rd(3, d); chk("R7 later read clears", d, 1);
    msg_valid = 1; msg_addr = AW'(4); msg_data = 1;
    ack_valid = 1; ack_addr = AW'(4);
    @(negedge clk); msg_valid = 0; ack_valid = 0;
    chk("R7 read sees idle before new", ack_rdata, 0);
    reg_rd(4'h0, d); chk("R7 new message pending", d, 32'h2);
    ack_rd(1, d);

    msg(1, 3);
    reg_rd(4'h4, d); chk("R8 data mismatch", d, 32'h1);
    reg_rd(4'h0, d); chk("R8 mismatch not latched", d, 0);
    msg(6, 6);
    reg_rd(4'h4, d); chk("R8 out-of-range slot", d, 32'h3);
    reg_wr(4'h4, 32'h1);
    reg_rd(4'h4, d); chk("R8 write-one clears one bit", d, 32'h2);
    msg_valid = 1; msg_addr = AW'(4); msg_data = 0;
    reg_valid = 1; reg_write = 1; reg_addr = 4'h4; reg_wdata = 32'h1;
    @(negedge clk); msg_valid = 0; reg_valid = 0; reg_write = 0;
    reg_rd(4'h4, d); chk("R8 new error beats clear", d, 32'h3);
    reg_wr(4'h4, 32'h3);
    msg_valid = 1; msg_addr = AW'(9); msg_data = 2;
    @(negedge clk); msg_valid = 0;
    reg_rd(4'h4, d); chk("R8 misaligned message", d, 32'h2);
    reg_rd(4'h0, d); chk("R8 misaligned not latched", d, 0);
    chk("R6 irq idle", 32'(irq), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule